// File: doc/BRIEF.md
# UART Grouped Interrupt Controller

This block gathers eleven interrupt events of a serial port into one raw status word. Each event source in the receiver, transmitter, modem-status and line-error logic drives a one-cycle set pulse on its own bit. Software owns an enable mask. It reads the raw word and the masked word, and it clears pending bits by writing ones to a clear address.

The masked word feeds six interrupt lines, each one a registered OR over a fixed group of bits:
- one combined line over every source;
- one receive line;
- one transmit line;
- one receive-timeout line;
- one modem-status line;
- one line-error line.

A system can wire only the combined line to its interrupt controller, or it can route the individual lines to separate handlers.

The register port is a single-cycle write strobe and a combinational read, with a 2-bit word address:
- 0: mask, read/write.
- 1: raw status, read only.
- 2: masked status, read only.
- 3: clear, write only, reads zero.

Top module: `uart_irq_hub`

## Requirements
- R1: A set pulse on `src_set[i]` makes raw bit i read as 1 from address 1 after the next clock edge. The bit meanings are: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit, 4 receive, 3 DSR, 2 DCD, 1 CTS, 0 ring indicator.
- R2: Address 2 reads raw status ANDed with the mask register at address 0.
- R3: A write to address 3 clears each raw bit whose written bit is 1 and leaves every other raw bit unchanged.
- R4: When a set pulse and a clear write hit the same bit in one cycle, the bit ends up set.
- R5: `irq_err` is the OR of masked bits 10, 9, 8 and 7.
- R6: `irq_modem` is the OR of masked bits 3, 2, 1 and 0.
- R7: `irq_any` is the OR of all eleven masked bits.
- R8: `irq_rx`, `irq_tx` and `irq_timeout` follow masked bits 4, 5 and 6 respectively.
- R9: All six outputs are registered. After a mask write, a set pulse or a clear write, they reflect the new state after the same clock edge that updates the registers.
- R10: Reset clears the raw status, the mask and all six outputs.
- R11: Read bits 31:11 are always zero. Written bits 31:11 are ignored. Writes to addresses 1 and 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_set | input | 11 | Per-source set pulses |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_timeout | output | 1 | Receive-timeout interrupt |
| irq_modem | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Line-error interrupt |

## Verification
The hardest case to reach from the ports is a set pulse and a clear write that land on the same bit in the same clock cycle. Separate tasks would place them in different cycles. The collision scenario therefore drives `src_set` and the clear-address write on the same falling edge, so that both are sampled by one rising edge. It then reads the raw word back to confirm that only the colliding bit survives. Group routing is covered by walking a single pending bit through all eleven positions and by opening the mask one group at a time.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int unsigned NSRC   = 11;
    localparam int unsigned NLINES = 6;

    // Line indices of the interrupt output vector
    localparam int unsigned LN_ANY = 0;
    localparam int unsigned LN_RX  = 1;
    localparam int unsigned LN_TX  = 2;
    localparam int unsigned LN_RTO = 3;
    localparam int unsigned LN_MS  = 4;
    localparam int unsigned LN_ERR = 5;

    localparam logic [NSRC-1:0] GRP_ERR = 11'h780; // overrun, break, parity, framing
    localparam logic [NSRC-1:0] GRP_RTO = 11'h040;
    localparam logic [NSRC-1:0] GRP_TX  = 11'h020;
    localparam logic [NSRC-1:0] GRP_RX  = 11'h010;
    localparam logic [NSRC-1:0] GRP_MS  = 11'h00F; // DSR, DCD, CTS, ring
    localparam logic [NSRC-1:0] GRP_ANY = GRP_ERR | GRP_RTO | GRP_TX | GRP_RX | GRP_MS;

    typedef enum logic [1:0] {
        A_MASK   = 2'd0,
        A_RAW    = 2'd1,
        A_MASKED = 2'd2,
        A_CLEAR  = 2'd3
    } reg_addr_e;

    function automatic logic [NSRC-1:0] line_group(input int unsigned ln);
        case (ln)
            LN_ANY:  return GRP_ANY;
            LN_RX:   return GRP_RX;
            LN_TX:   return GRP_TX;
            LN_RTO:  return GRP_RTO;
            LN_MS:   return GRP_MS;
            default: return GRP_ERR;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_en_i,
    input  logic [NSRC-1:0] clr_bits_i,
    output logic [NSRC-1:0] raw_d_o,
    output logic [NSRC-1:0] raw_q_o
);
    typedef struct packed {
        logic [NSRC-1:0] raw;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en_i) begin
            st_d.raw = st_d.raw & ~clr_bits_i;
        end
        st_d.raw = st_d.raw | set_i; // set takes priority over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_d_o = st_d.raw;
    assign raw_q_o = st_q.raw;

    // R4: every pulsed bit is pending after the edge, whatever the clear said
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((st_q.raw & $past(set_i)) == $past(set_i)));

    // R3: cleared bits that were not set again in that cycle are gone
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((st_q.raw & $past(clr_bits_i & ~set_i)) == '0));

    // R3: bits neither cleared nor set keep their value
    a_r3_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.raw & ~$past(set_i) & ~($past(clr_en_i) ? $past(clr_bits_i) : '0))
                  == ($past(st_q.raw) & ~$past(set_i) & ~($past(clr_en_i) ? $past(clr_bits_i) : '0))));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] mask_d_o,
    output logic [NSRC-1:0] mask_q_o
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_d_o = st_d.mask;
    assign mask_q_o = st_q.mask;

    // R9: a mask write lands after one edge
    a_r9_mask_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.mask == $past(wdata_i)));

    // R11: without a write the mask holds
    a_r11_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q.mask));
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   masked_d_i,
    output logic [NLINES-1:0] line_o
);
    typedef struct packed {
        logic [NLINES-1:0] line;
    } st_t;

    st_t st_d, st_q;
    logic [NLINES-1:0] line_next;

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        assign line_next[l] = |(masked_d_i & line_group(l));
    end

    always_comb begin
        st_d      = st_q;
        st_d.line = line_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.line;

    // R7: combined line is high exactly when some grouped line is high
    a_r7_any_covers: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.line[LN_ANY] == (|st_q.line[NLINES-1:1]));
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
    import uart_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   src_set,
    output logic              irq_any,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_timeout,
    output logic              irq_modem,
    output logic              irq_err
);
    localparam int unsigned PAD_W = DATA_W - NSRC;

    logic [NSRC-1:0]   raw_d, raw_q, mask_d, mask_q, masked_q;
    logic [NLINES-1:0] lines;
    logic              wr_mask, wr_clear;

    assign wr_mask  = reg_wr && (reg_addr == A_MASK);
    assign wr_clear = reg_wr && (reg_addr == A_CLEAR);

    uart_irq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_set),
        .clr_en_i   (wr_clear),
        .clr_bits_i (reg_wdata[NSRC-1:0]),
        .raw_d_o    (raw_d),
        .raw_q_o    (raw_q)
    );

    uart_irq_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_mask),
        .wdata_i  (reg_wdata[NSRC-1:0]),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q)
    );

    uart_irq_lines u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .masked_d_i (raw_d & mask_d),
        .line_o     (lines)
    );

    assign masked_q = raw_q & mask_q;

    always_comb begin
        unique case (reg_addr)
            A_MASK:   reg_rdata = {{PAD_W{1'b0}}, mask_q};
            A_RAW:    reg_rdata = {{PAD_W{1'b0}}, raw_q};
            A_MASKED: reg_rdata = {{PAD_W{1'b0}}, masked_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_any     = lines[LN_ANY];
    assign irq_rx      = lines[LN_RX];
    assign irq_tx      = lines[LN_TX];
    assign irq_timeout = lines[LN_RTO];
    assign irq_modem   = lines[LN_MS];
    assign irq_err     = lines[LN_ERR];

    // R5, R6, R8, R9: registered lines agree with the registered state
    a_r5_err_group: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err == |(raw_q & mask_q & GRP_ERR));
    a_r6_modem_group: assert property (@(posedge clk) disable iff (!rst_n)
        irq_modem == |(raw_q & mask_q & GRP_MS));
    a_r8_single_lines: assert property (@(posedge clk) disable iff (!rst_n)
        {irq_timeout, irq_tx, irq_rx} == {masked_q[6], masked_q[5], masked_q[4]});
    // R11: upper read bits stay zero
    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NSRC] == '0);
endmodule

// File: tb/uart_irq_hub_tb_top.sv
module uart_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] src_set = '0;
    logic irq_any, irq_rx, irq_tx, irq_timeout, irq_modem, irq_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [10:0] m_raw = '0;
    logic [10:0] m_mask = '0;

    always #10 clk = ~clk; // 50 MHz

    uart_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_set(src_set),
        .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .irq_timeout(irq_timeout), .irq_modem(irq_modem), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Order {err, modem, timeout, tx, rx, any}
    function automatic logic [5:0] exp_lines(input logic [10:0] r, input logic [10:0] m);
        logic [10:0] v = r & m;
        return {|v[10:7], |v[3:0], v[6], v[5], v[4], |v};
    endfunction

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        if (a == 2'd0) m_mask = d[10:0];
        if (a == 2'd3) m_raw = m_raw & ~d[10:0];
    endtask

    task automatic pulse(input logic [10:0] s);
        src_set = s;
        @(negedge clk);
        src_set = '0;
        m_raw = m_raw | s;
    endtask

    task automatic chk_lines(input string req);
        chk(req, {26'd0, irq_err, irq_modem, irq_timeout, irq_tx, irq_rx, irq_any},
            {26'd0, exp_lines(m_raw, m_mask)});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R10 mask", d, 0);
        rd(2'd1, d); chk("R10 raw", d, 0);
        chk("R10 lines", {26'd0, irq_err, irq_modem, irq_timeout, irq_tx, irq_rx, irq_any}, 0);
    endtask

    task automatic t_walk();
        logic [31:0] d;
        wr(2'd0, 32'h7FF);
        for (int i = 0; i < 11; i++) begin
            pulse(11'(1) << i);
            rd(2'd1, d); chk($sformatf("R1 bit %0d", i), d, 32'(1) << i);
            chk_lines("R5/R6/R7/R8 walk");
            wr(2'd3, 32'h7FF);
            rd(2'd1, d); chk("R3 clear all", d, 0);
        end
    endtask

    task automatic t_groups();
        logic [31:0] d;
        logic [10:0] g[6] = '{11'h780, 11'h00F, 11'h040, 11'h020, 11'h010, 11'h000};
        pulse(11'h7FF);
        wr(2'd0, 0);
        chk_lines("R9 all masked off");
        rd(2'd2, d); chk("R2 masked zero", d, 0);
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, {21'd0, g[k]});
            chk_lines("R9 group mask");
            rd(2'd2, d); chk("R2 masked read", d, {21'd0, g[k]});
        end
        wr(2'd0, 32'h0A5);
        wr(2'd3, 32'h005);
        chk_lines("R6 partial modem");
        rd(2'd2, d); chk("R2 masked mix", d, 32'h0A0);
    endtask

    task automatic t_partial_clear();
        logic [31:0] d;
        pulse(11'h7FF);
        wr(2'd3, 32'h0F0);
        rd(2'd1, d); chk("R3 partial", d, 32'h70F);
        wr(2'd0, 32'h780);
        wr(2'd3, 32'h380);
        chk_lines("R5 err remaining");
        wr(2'd3, 32'h400);
        chk_lines("R5 err gone");
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(2'd3, 32'h7FF);
        pulse(11'h00C);
        src_set = 11'h024;
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h7FF;
        @(negedge clk);
        reg_wr = 1'b0; src_set = '0; reg_wdata = '0;
        m_raw = 11'h024;
        rd(2'd1, d); chk("R4 set wins", d, 32'h024);
        wr(2'd0, 32'h020);
        chk_lines("R4 tx line");
    endtask

    task automatic t_upper();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_F801);
        rd(2'd0, d); chk("R11 mask upper", d, 32'h001);
        wr(2'd3, 32'h7FF);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_addr = 2'd2;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd1, d); chk("R11 raw read-only", d, 0);
        rd(2'd0, d); chk("R11 mask unchanged", d, 32'h001);
        rd(2'd3, d); chk("R11 clear reads zero", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk();
        t_groups();
        t_partial_clear();
        t_collide();
        t_upper();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule